// File: doc/BRIEF.md
# Coprocessor Wake and Bus-Access Sequencer

This block lives in a host controller next to a separate I2C controller. It drives the sideband lines of a sensor coprocessor that can sleep. When local logic asks for a bus transaction, the sequencer raises an active-high wake line. It then makes the I2C controller wait until a settle interval, counted in system clock cycles, has run out. Only after that does it grant the bus. The grant is held until the I2C engine reports that it is done.

Once the I2C side reports that a sleep power command has gone out, the sequencer drops the wake line and returns to its sleeping phase. In that phase only a fresh wake, with the full settle wait repeated, can bring the coprocessor back. Host bus traffic on its own is not enough.

Two further duties run beside this. The sequencer synchronises the coprocessor's active-low data-ready alert and keeps a sticky flag that software clears. It can also pulse an active-low reset that clears the coprocessor's host-side I2C port. That pulse cancels any grant and restarts the settle wait.

Top module: `cp_wake_seq`

## Requirements
- R1: While and after synchronous reset, `phase` is 00, `wake_out` and `grant` are 0, `port_rst_n` is 1 and `data_ready` is 0.
- R2: `phase` encodes the sequencer state as 00 asleep, 01 waking, 10 ready, 11 busy. A `xfer_req` sampled while asleep moves it to waking on the next cycle.
- R3: The waking phase lasts exactly `SETTLE_CYCLES` cycles and then becomes ready. `grant` never rises unless `wake_out` has been high for at least `SETTLE_CYCLES` cycles.
- R4: `grant` rises only on the cycle after a `xfer_req` sampled in ready, when the phase becomes busy. It stays high until a sampled `xfer_done`, after which the phase is ready again.
- R5: `xfer_req` has no effect in waking or busy, and `xfer_done` has no effect outside busy.
- R6: A sampled `sleep_sent` in any phase leads to asleep with `wake_out` and `grant` low on the next cycle. A later `xfer_req` repeats the whole settle wait.
- R7: A sampled `port_rst_req`, with no `sleep_sent` in the same cycle, drives `port_rst_n` low for exactly `RST_PULSE_CYCLES` cycles starting on the next cycle. It also drops `grant` and enters waking with the settle count restarted.
- R8: When `sleep_sent` and `port_rst_req` are sampled in the same cycle, the sleep wins. The phase becomes asleep and no reset pulse starts.
- R9: A falling edge on `alert_n_in` sets `data_ready` three cycles after the input falls: two synchroniser stages plus the flag register. A level that stays low does not set the flag again after a clear.
- R10: `flag_clr` clears `data_ready` on the next cycle. If a detected falling edge arrives in the same cycle, the set wins.
- R11: `wake_out` is high exactly when `phase` is not asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_req | input | 1 | Local request for a bus transaction |
| xfer_done | input | 1 | I2C engine finished the granted transaction |
| sleep_sent | input | 1 | Strobe: sleep power command was sent |
| port_rst_req | input | 1 | Request a reset pulse of the coprocessor's host I2C port |
| flag_clr | input | 1 | Software clear of the data-ready flag |
| alert_n_in | input | 1 | Asynchronous active-low data-ready alert from the coprocessor |
| wake_out | output | 1 | Active-high wake line to the coprocessor |
| grant | output | 1 | Bus access granted to the I2C engine |
| port_rst_n | output | 1 | Active-low reset of the coprocessor's host I2C port |
| data_ready | output | 1 | Sticky flag: coprocessor has data for the host |
| phase | output | 2 | Current sequencer state (encoding in R2) |

## Verification
Two requests can collide in one cycle. A sleep strobe and a port-reset request can arrive together, and an alert edge can be detected in the same cycle that software clears the flag. The bench makes the first collision by raising `sleep_sent` and `port_rst_req` on the same clock while busy. It judges the result by `phase` going to 00 and `port_rst_n` staying high. For the second, it times `flag_clr` to meet the third cycle after `alert_n_in` falls, then expects `data_ready` to read 1. A behavioural model checks both outcomes every clock, and they are also checked directly.

// File: rtl/cp_wake_pkg.sv
package cp_wake_pkg;
  typedef enum logic [1:0] {
    PH_ASLEEP = 2'b00,
    PH_WAKING = 2'b01,
    PH_READY  = 2'b10,
    PH_BUSY   = 2'b11
  } phase_t;
endpackage

// File: rtl/cp_settle_timer.sv
module cp_settle_timer #(
  parameter int SETTLE_CYCLES = 528000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (en && cnt != LAST)
      cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LAST);
endmodule

// File: rtl/cp_alert_sync.sv
module cp_alert_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic alert_n,
  input  logic clr,
  output logic data_ready
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh;
  logic            fall;

  always_ff @(posedge clk) begin
    if (rst)
      sh <= '1;
    else
      sh <= {sh[STAGES-1:0], alert_n};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)
      data_ready <= 1'b0;
    else if (fall)
      data_ready <= 1'b1;
    else if (clr)
      data_ready <= 1'b0;
  end
endmodule

// File: rtl/cp_rst_pulse.sv
module cp_rst_pulse #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic port_rst_n
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] LOAD = PW'(PULSE_CYCLES);

  logic [PW-1:0] cnt, cnt_n;

  always_comb begin
    if (fire)
      cnt_n = LOAD;
    else if (cnt != '0)
      cnt_n = cnt - 1'b1;
    else
      cnt_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      port_rst_n <= 1'b1;
    end else begin
      cnt        <= cnt_n;
      port_rst_n <= (cnt_n == '0);
    end
  end
endmodule

// File: rtl/cp_wake_seq.sv
module cp_wake_seq
  import cp_wake_pkg::*;
#(
  parameter int SETTLE_CYCLES    = 528000,
  parameter int RST_PULSE_CYCLES = 16,
  parameter int SYNC_STAGES      = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       xfer_req,
  input  logic       xfer_done,
  input  logic       sleep_sent,
  input  logic       port_rst_req,
  input  logic       flag_clr,
  input  logic       alert_n_in,
  output logic       wake_out,
  output logic       grant,
  output logic       port_rst_n,
  output logic       data_ready,
  output logic [1:0] phase
);
  phase_t state, nxt;
  logic   fire;
  logic   tmr_clr, tmr_done;

  // sleep strobe outranks a reset request in the same cycle
  assign fire = port_rst_req & ~sleep_sent;

  always_comb begin
    nxt = state;
    if (sleep_sent)
      nxt = PH_ASLEEP;
    else if (port_rst_req)
      nxt = PH_WAKING;
    else begin
      unique case (state)
        PH_ASLEEP: if (xfer_req)  nxt = PH_WAKING;
        PH_WAKING: if (tmr_done)  nxt = PH_READY;
        PH_READY:  if (xfer_req)  nxt = PH_BUSY;
        PH_BUSY:   if (xfer_done) nxt = PH_READY;
      endcase
    end
  end

  assign tmr_clr = (nxt == PH_WAKING) && ((state != PH_WAKING) || fire);

  cp_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) timer_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (tmr_clr),
    .en   (state == PH_WAKING),
    .done (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PH_ASLEEP;
      wake_out <= 1'b0;
      grant    <= 1'b0;
    end else begin
      state    <= nxt;
      wake_out <= (nxt != PH_ASLEEP);
      grant    <= (nxt == PH_BUSY);
    end
  end

  assign phase = state;

  cp_rst_pulse #(.PULSE_CYCLES(RST_PULSE_CYCLES)) pulse_i (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .port_rst_n (port_rst_n)
  );

  cp_alert_sync #(.STAGES(SYNC_STAGES)) alert_i (
    .clk        (clk),
    .rst        (rst),
    .alert_n    (alert_n_in),
    .clr        (flag_clr),
    .data_ready (data_ready)
  );
endmodule

// File: rtl/cp_wake_seq_chk.sv
module cp_wake_seq_chk #(
  parameter int SETTLE_CYCLES = 528000
) (
  input logic       clk,
  input logic       rst,
  input logic       xfer_req,
  input logic       xfer_done,
  input logic       sleep_sent,
  input logic       port_rst_req,
  input logic       flag_clr,
  input logic       wake_out,
  input logic       grant,
  input logic       port_rst_n,
  input logic       data_ready,
  input logic [1:0] phase
);
  int wake_run;

  always_ff @(posedge clk) begin
    if (rst || !wake_out)
      wake_run <= 0;
    else if (wake_run < SETTLE_CYCLES)
      wake_run <= wake_run + 1;
  end

  // R11
  wake_phase_chk: assert property (@(posedge clk) disable iff (rst)
    wake_out == (phase != 2'b00));

  // R3
  settle_before_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(grant) |-> wake_run >= SETTLE_CYCLES);

  // R4
  grant_from_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(grant) |-> ($past(phase) == 2'b10 && $past(xfer_req)));

  // R5
  done_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b10 && xfer_done && !xfer_req && !sleep_sent && !port_rst_req)
      |=> phase == 2'b10);

  // R6
  sleep_drop_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_sent |=> (phase == 2'b00 && !wake_out && !grant));

  // R7
  port_rst_start_chk: assert property (@(posedge clk) disable iff (rst)
    (port_rst_req && !sleep_sent) |=> (!port_rst_n && phase == 2'b01 && !grant));

  // R8
  sleep_beats_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_sent && port_rst_req && port_rst_n) |=> port_rst_n);

  // R10
  flag_fall_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(data_ready) |-> $past(flag_clr));
endmodule

bind cp_wake_seq cp_wake_seq_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .xfer_req     (xfer_req),
  .xfer_done    (xfer_done),
  .sleep_sent   (sleep_sent),
  .port_rst_req (port_rst_req),
  .flag_clr     (flag_clr),
  .wake_out     (wake_out),
  .grant        (grant),
  .port_rst_n   (port_rst_n),
  .data_ready   (data_ready),
  .phase        (phase)
);

// File: tb/cp_wake_seq_tb_top.sv
module cp_wake_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 20;
  localparam int RSTP       = 4;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xfer_req = 0, xfer_done = 0, sleep_sent = 0, port_rst_req = 0;
  logic flag_clr = 0, alert_n_in = 1;
  logic wake_out, grant, port_rst_n, data_ready;
  logic [1:0] phase;

  int n_tests = 0;
  int n_fail  = 0;
  bit started = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cp_wake_seq #(.SETTLE_CYCLES(SETTLE), .RST_PULSE_CYCLES(RSTP)) dut_i (
    .clk(clk), .rst(rst), .xfer_req(xfer_req), .xfer_done(xfer_done),
    .sleep_sent(sleep_sent), .port_rst_req(port_rst_req), .flag_clr(flag_clr),
    .alert_n_in(alert_n_in), .wake_out(wake_out), .grant(grant),
    .port_rst_n(port_rst_n), .data_ready(data_ready), .phase(phase)
  );

  // behavioural reference model
  int m_st = 0, m_tmr = 0, m_pulse = 0, m_flag = 0;
  int a1 = 1, a2 = 1, a3 = 1;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_st = 0; m_tmr = 0; m_pulse = 0; m_flag = 0;
      a1 = 1; a2 = 1; a3 = 1;
    end else begin
      if (a3 == 1 && a2 == 0) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      a3 = a2; a2 = a1; a1 = int'(alert_n_in);
      if (port_rst_req && !sleep_sent) m_pulse = RSTP;
      else if (m_pulse > 0) m_pulse = m_pulse - 1;
      if (sleep_sent) m_st = 0;
      else if (port_rst_req) begin m_st = 1; m_tmr = 0; end
      else case (m_st)
        0: if (xfer_req) begin m_st = 1; m_tmr = 0; end
        1: if (m_tmr == SETTLE - 1) m_st = 2; else m_tmr = m_tmr + 1;
        2: if (xfer_req) m_st = 3;
        default: if (xfer_done) m_st = 2;
      endcase
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R2 phase", int'(phase), m_st);
      chk("R11 wake_out", int'(wake_out), int'(m_st != 0));
      chk("R4 grant", int'(grant), int'(m_st == 3));
      chk("R7 port_rst_n", int'(port_rst_n), int'(m_pulse == 0));
      chk("R9 data_ready", int'(data_ready), m_flag);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_waking(string tag);
    int n = 0;
    while (phase == 2'b01 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(tag, n, SETTLE);
  endtask

  initial begin
    cyc(4);
    // R1 reset state
    chk("R1 phase", int'(phase), 0);
    chk("R1 outs", int'({wake_out, grant, port_rst_n, data_ready}), 4'b0010);
    rst = 0;
    cyc(2);
    // R5: done while asleep is ignored
    xfer_done = 1; cyc(1); xfer_done = 0; cyc(1);
    chk("R5 done asleep", int'(phase), 0);
    // R2/R3 wake and settle
    xfer_req = 1; cyc(1); xfer_req = 0;
    count_waking("R3 settle length");
    cyc(2);
    chk("R3 ready", int'(phase), 2);
    // R4 grant
    xfer_req = 1; cyc(1); xfer_req = 0;
    chk("R4 grant high", int'(grant), 1);
    xfer_req = 1; cyc(3); xfer_req = 0;
    chk("R5 req in busy", int'(phase), 3);
    xfer_done = 1; cyc(1); xfer_done = 0;
    chk("R4 back ready", int'(phase), 2);
    // R6 sleep from busy, restart full wait
    xfer_req = 1; cyc(1); xfer_req = 0; cyc(2);
    sleep_sent = 1; cyc(1); sleep_sent = 0;
    chk("R6 asleep", int'({phase, wake_out, grant}), 0);
    cyc(3);
    xfer_req = 1; cyc(1); xfer_req = 0;
    count_waking("R6 restart wait");
    xfer_req = 1; cyc(1); xfer_req = 0; cyc(2);
    // R7 port reset from busy
    port_rst_req = 1; cyc(1); port_rst_req = 0;
    chk("R7 grant dropped", int'(grant), 0);
    begin
      int low = 0;
      while (!port_rst_n && low < 100) begin low++; cyc(1); end
      chk("R7 pulse width", low, RSTP);
    end
    while (phase != 2'b10) cyc(1);
    xfer_req = 1; cyc(1); xfer_req = 0; cyc(1);
    // R8 sleep and port reset together
    sleep_sent = 1; port_rst_req = 1; cyc(1);
    sleep_sent = 0; port_rst_req = 0;
    chk("R8 phase", int'(phase), 0);
    chk("R8 no pulse", int'(port_rst_n), 1);
    cyc(2);
    // R9 alert edge, latency 3
    alert_n_in = 0; cyc(2);
    chk("R9 not yet", int'(data_ready), 0);
    cyc(1);
    chk("R9 set", int'(data_ready), 1);
    flag_clr = 1; cyc(1); flag_clr = 0; cyc(4);
    chk("R9 level no reset", int'(data_ready), 0);
    // R10 set beats clear in the same cycle
    alert_n_in = 1; cyc(4);
    alert_n_in = 0; cyc(2);
    flag_clr = 1; cyc(1); flag_clr = 0;
    chk("R10 set wins", int'(data_ready), 1);
    flag_clr = 1; cyc(1); flag_clr = 0;
    chk("R10 cleared", int'(data_ready), 0);
    cyc(3);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected finished before %0d cycles", WATCHDOG, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule